// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

Two memory ports, left and right, share one storage array. Each port presents an enable, a write strobe and an address every clock. When both ports are enabled on the same address, the arbiter grants that location to one port. It drives an active-low busy flag to the other port and keeps the grant until the contention ends. The storage array uses a per-port qualified write strobe from this block, so a port that is told it is busy cannot complete a write.

A mode input makes the block either a master or a slave. In master mode the block decides the grant and drives its busy outputs. In slave mode the busy outputs stay inactive, and the block takes busy flags from an external master and uses them to gate writes. Several devices wired in this way share one arbitration decision and so form a wider word.

Top module: `dpa_contention_arbiter`

## Requirements
- R1: Contention is recognised only when both enables are high and both addresses are equal. In every other case both busy outputs stay high (1 = not busy).
- R2: When one port was already enabled on an address in the previous cycle and the other port then arrives on that same address, the port that was there first keeps access. The newcomer receives busy (low).
- R3: When neither port was enabled on the contended address in the previous cycle, the contention is a simultaneous start. The left port wins and busy goes to the right port.
- R4: Busy is registered. It changes in the cycle after the clock edge that samples the start of contention. It returns high in the cycle after the edge that samples an address mismatch or a deasserted enable.
- R5: While both ports remain matched, the grant does not change, even if both addresses move together to a new equal value.
- R6: The two busy outputs are never low at the same time. After any edge that samples contention in master mode, exactly one of them is low.
- R7: With master_mode = 1 the busy outputs carry the block's own decision. With master_mode = 0 both busy outputs are held high.
- R8: With master_mode = 0, each qualified write equals that port's write strobe ANDed with its busy input (active low). With master_mode = 1 the busy inputs have no effect.
- R9: With master_mode = 1, each qualified write equals that port's write strobe ANDed with that port's own busy output.
- R10: A synchronous active-low reset drives both busy outputs high, clears the grant and clears the arrival history. Contention present when reset is released is therefore treated as a simultaneous start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_mode | input | 1 | 1 = master (drives busy), 0 = slave (takes busy) |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port raw write strobe |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port raw write strobe |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | Busy from external master to left port, active low (slave mode) |
| r_busy_in_n | input | 1 | Busy from external master to right port, active low (slave mode) |
| l_busy_out_n | output | 1 | Busy to left port, active low |
| r_busy_out_n | output | 1 | Busy to right port, active low |
| l_wr_ok | output | 1 | Left write strobe qualified by not-busy |
| r_wr_ok | output | 1 | Right write strobe qualified by not-busy |

## Verification
Every cycle, the assertions check these properties:
- The two busy outputs are never low together.
- Sampled contention always produces a grant.
- A held grant does not flip while the match persists.
- Busy releases one cycle after the match ends.
- In slave mode, a busy input blocks its port's write.
- Reset clears both flags.

Only the bench scenarios can show which port wins. They cover the right port arriving first, a simultaneous start, an address shift made together by both ports, a switch from slave to master mode with stale busy inputs, and a reset released while the ports are still contending.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   localparam int NUM_PORTS = 2;
   localparam int PORT_L    = 0;
   localparam int PORT_R    = 1;

   typedef enum logic [1:0] {
      GR_NONE  = 2'd0,
      GR_LEFT  = 2'd1,
      GR_RIGHT = 2'd2
   } grant_e;
endpackage

// File: rtl/dpa_match_detect.sv
module dpa_match_detect
   import dpa_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] en,
   input  logic [ADDR_W-1:0]    addr [NUM_PORTS],
   output logic                 match,
   output logic [NUM_PORTS-1:0] held
);
   logic [NUM_PORTS-1:0] prev_en;
   logic [ADDR_W-1:0]    prev_addr [NUM_PORTS];

   assign match = en[PORT_L] & en[PORT_R] & (addr[PORT_L] == addr[PORT_R]);

   // a port is "held" when it sat on the same address in the previous cycle
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hist
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_en[p]   <= 1'b0;
            prev_addr[p] <= '0;
         end else begin
            prev_en[p]   <= en[p];
            prev_addr[p] <= addr[p];
         end
      end
      assign held[p] = en[p] & prev_en[p] & (prev_addr[p] == addr[p]);
   end
endmodule

// File: rtl/dpa_grant_fsm.sv
module dpa_grant_fsm
   import dpa_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 match,
   input  logic [NUM_PORTS-1:0] held,
   output grant_e               grant
);
   grant_e grant_nxt;

   always_comb begin
      grant_nxt = grant;
      if (!match)
         grant_nxt = GR_NONE;
      else if (grant == GR_NONE)
         grant_nxt = (held[PORT_R] && !held[PORT_L]) ? GR_RIGHT : GR_LEFT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) grant <= GR_NONE;
      else        grant <= grant_nxt;
   end

   // R6: sampled contention always yields a winner
   p_match_grants_r6: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (grant != GR_NONE));

   // R5: a standing grant persists while contention persists
   p_grant_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != GR_NONE && match) |=> $stable(grant));
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate
   import dpa_pkg::*;
(
   input  logic [NUM_PORTS-1:0] wr,
   input  logic [NUM_PORTS-1:0] busy_n,
   output logic [NUM_PORTS-1:0] wr_ok
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_gate
      assign wr_ok[p] = wr[p] & busy_n[p];
   end
endmodule

// File: rtl/dpa_contention_arbiter.sv
module dpa_contention_arbiter
   import dpa_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_busy_in_n,
   input  logic              r_busy_in_n,
   output logic              l_busy_out_n,
   output logic              r_busy_out_n,
   output logic              l_wr_ok,
   output logic              r_wr_ok
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..32");
   end

   logic [NUM_PORTS-1:0] en_v, wr_v, held_v, busy_loc_n, busy_eff_n, wr_ok_v;
   logic [ADDR_W-1:0]    addr_v [NUM_PORTS];
   logic                 match;
   grant_e               grant;

   assign en_v           = {r_en, l_en};
   assign wr_v           = {r_wr, l_wr};
   assign addr_v[PORT_L] = l_addr;
   assign addr_v[PORT_R] = r_addr;

   dpa_match_detect #(.ADDR_W(ADDR_W)) u_match (
      .clk(clk), .rst_n(rst_n), .en(en_v), .addr(addr_v),
      .match(match), .held(held_v)
   );

   dpa_grant_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .match(match), .held(held_v), .grant(grant)
   );

   // loser of the registered grant sees busy
   assign busy_loc_n[PORT_L] = (grant != GR_RIGHT);
   assign busy_loc_n[PORT_R] = (grant != GR_LEFT);

   assign busy_eff_n   = master_mode ? busy_loc_n : {r_busy_in_n, l_busy_in_n};
   assign l_busy_out_n = master_mode ? busy_loc_n[PORT_L] : 1'b1;
   assign r_busy_out_n = master_mode ? busy_loc_n[PORT_R] : 1'b1;

   dpa_write_gate u_gate (.wr(wr_v), .busy_n(busy_eff_n), .wr_ok(wr_ok_v));

   assign l_wr_ok = wr_ok_v[PORT_L];
   assign r_wr_ok = wr_ok_v[PORT_R];

   // R6: never both ports busy
   p_never_both_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_out_n && !r_busy_out_n));

   // R4: busy released the cycle after contention ends
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_en && r_en && l_addr == r_addr) |=> (l_busy_out_n && r_busy_out_n));

   // R8: slave mode never lets a busy port write
   p_slave_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && (!l_busy_in_n || !r_busy_in_n)) |->
         !((!l_busy_in_n && l_wr_ok) || (!r_busy_in_n && r_wr_ok)));

   // R10: reset leaves both flags inactive
   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |=> (l_busy_out_n && r_busy_out_n));
endmodule

// File: tb/dpa_contention_arbiter_test.sv
module dpa_contention_arbiter_test;
   localparam int AW = 16;

   typedef struct packed {
      logic          mm;
      logic          le, lw;
      logic [AW-1:0] la;
      logic          re, rw;
      logic [AW-1:0] ra;
      logic          bil, bir;
      logic          ebl, ebr, ewl, ewr;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 1'b1,1'b0,16'd10, 1'b0,1'b0,16'd0,  1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // R1 one port
      '{1'b1, 1'b1,1'b1,16'd10, 1'b1,1'b1,16'd10, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // R2 left first
      '{1'b1, 1'b1,1'b1,16'd10, 1'b1,1'b1,16'd10, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // R5 hold
      '{1'b1, 1'b1,1'b1,16'd11, 1'b1,1'b1,16'd10, 1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1}, // R4 mismatch
      '{1'b1, 1'b0,1'b0,16'd0,  1'b1,1'b0,16'd20, 1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // R1
      '{1'b1, 1'b1,1'b1,16'd20, 1'b1,1'b0,16'd20, 1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0}, // R2 right first
      '{1'b1, 1'b1,1'b1,16'd20, 1'b1,1'b0,16'd20, 1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0}, // R5 R9
      '{1'b1, 1'b1,1'b1,16'd20, 1'b0,1'b0,16'd20, 1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0}, // R4 enable off
      '{1'b1, 1'b0,1'b0,16'd0,  1'b0,1'b0,16'd0,  1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // idle
      '{1'b1, 1'b1,1'b0,16'd30, 1'b1,1'b1,16'd30, 1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0}, // R3 tie
      '{1'b1, 1'b1,1'b0,16'd31, 1'b1,1'b1,16'd31, 1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0}, // R5 shift
      '{1'b1, 1'b1,1'b1,16'd32, 1'b1,1'b1,16'd33, 1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1}, // R1 diff addr
      '{1'b1, 1'b1,1'b0,16'd40, 1'b0,1'b0,16'd40, 1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}, // R1 right off
      '{1'b0, 1'b1,1'b1,16'd50, 1'b1,1'b1,16'd50, 1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0}, // R7 R8 slave
      '{1'b0, 1'b1,1'b1,16'd50, 1'b1,1'b1,16'd50, 1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1}, // R8
      '{1'b0, 1'b1,1'b1,16'd50, 1'b1,1'b1,16'd50, 1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1}, // R8
      '{1'b1, 1'b1,1'b1,16'd50, 1'b1,1'b1,16'd50, 1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0}, // R7 R8 master
      '{1'b1, 1'b0,1'b0,16'd50, 1'b0,1'b0,16'd50, 1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0}  // R4
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_mode = 1'b1;
   logic l_en = 1'b0, l_wr = 1'b0, r_en = 1'b0, r_wr = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
   logic l_busy_out_n, r_busy_out_n, l_wr_ok, r_wr_ok;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   dpa_contention_arbiter #(.ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
      .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
      .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
      .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
      .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
   );

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s {lbusy,rbusy,lwr,rwr} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      master_mode = v.mm;
      l_en = v.le; l_wr = v.lw; l_addr = v.la;
      r_en = v.re; r_wr = v.rw; r_addr = v.ra;
      l_busy_in_n = v.bil; r_busy_in_n = v.bir;
   endtask

   function automatic logic [3:0] outs();
      return {l_busy_out_n, r_busy_out_n, l_wr_ok, r_wr_ok};
   endfunction

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      vec_t v;
      repeat (3) @(negedge clk);
      check("R10 reset state", outs(), 4'b1100);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i]);
         @(negedge clk);
         check($sformatf("vector %0d", i), outs(), {TBL[i].ebl, TBL[i].ebr, TBL[i].ewl, TBL[i].ewr});
      end

      // R10: reset during contention, then release while still matched
      v = '{1'b1, 1'b0,1'b0,16'd60, 1'b1,1'b1,16'd60, 1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0};
      drive(v);
      @(negedge clk);
      v.le = 1'b1; v.lw = 1'b1;
      drive(v);
      @(negedge clk);
      check("R2 right first before reset", outs(), 4'b0101);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 busy cleared in reset", outs(), 4'b1111);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 history cleared -> left wins", outs(), 4'b1010);

      // R6: winner persists for several cycles, never both busy
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R6 exactly one busy", outs(), 4'b1010);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule